// File: doc/BRIEF.md
# CPU Slot Hotplug Control Registers

This block is a small register file through which firmware or an operating system walks a fixed set of hot-pluggable CPU slots. Software picks a slot by writing a selector, then issues one-byte commands. The commands either search for the next slot with an unhandled event, fetch the slot's 64-bit architecture identifier through two 32-bit read windows, or latch event and status codes that are reported to the platform.

Each slot has three inputs: an enabled level, an insert-event set pulse and a remove-event set pulse. The block holds a pending insert flag and a pending remove flag for each slot. Software clears these flags by writing ones to the status byte. A level output, `notify`, stays high while any flag is pending. Reads are combinational from the address, and writes take effect on the rising clock edge. Write data is aligned to bit 0 of `wdata`, and multi-byte values are little endian.

Top module: `cpu_slot_ctl`

## Requirements
- R1: After reset the selector and command are 0, the stored event and status codes are 0, no flag is pending, `notify` is low and offset 0x8 reads 0.
- R2: Offset 0x4 reads the status byte of the selected slot: bit 0 = enabled, bit 1 = insert pending, bit 2 = remove pending, and all other bits 0.
- R3: A write to offset 0x8 loads the selector when the current command is 0, 3, or 4 and above.
- R4: Writing command 0 to offset 0x5 scans slots from the current selector upward. The selector moves to the first slot with a pending flag, or stays the same if there is none. With command 0, offset 0x8 reads the selector.
- R5: With command 3 and a valid selector, offset 0x8 reads bits 31:0 of the selected slot's ID and offset 0x0 reads bits 63:32.
- R6: With a selector at or above the slot count, offsets 0x0, 0x4 and 0x8 read 0, and a clear write to 0x4 changes no slot's flags.
- R7: Offset 0x0 reads 0 for every command other than 3. Offset 0x8 reads 0 for commands 1, 2 and 4 and above.
- R8: With command 1, a write to 0x8 stores the value as the event code on `rpt_event` and leaves the selector unchanged.
- R9: With command 2, a write to 0x8 stores the value as the status code on `rpt_status`. `rpt_valid` is high for exactly the one cycle after that write.
- R10: Writing 1 to bit 1 or bit 2 at 0x4 clears the selected slot's insert or remove flag. Other bits have no effect. A set pulse in the same cycle wins over a clear.
- R11: `notify` is high from the cycle after any set pulse until all flags are cleared.
- R12: Offsets other than 0x0, 0x4 and 0x8, including the command byte 0x5, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Byte offset |
| wdata | input | 32 | Write data, aligned to bit 0 |
| rdata | output | 32 | Read data for `addr` |
| slot_en | input | NSLOT | Per-slot enabled level |
| ins_set | input | NSLOT | Per-slot insert event pulse |
| rem_set | input | NSLOT | Per-slot remove event pulse |
| slot_id | input | NSLOT*64 | Per-slot 64-bit ID, slot i at bits 64i+63:64i |
| notify | output | 1 | High while any flag is pending |
| rpt_valid | output | 1 | One-cycle report pulse |
| rpt_event | output | 32 | Stored event code |
| rpt_status | output | 32 | Stored status code |

## Verification
A corrupted selector or command register shows up at once on the next read of 0x8 or 0x0. The wrong slot's ID or a zero appears in the same cycle the address is presented. A search that stops at the wrong slot, or that moves the selector when nothing is pending, is visible on the first read of 0x8 after the command write. A pending flag that is lost or that sticks is visible both on `notify` one cycle after the event and on the status byte of that slot.

// File: rtl/cpu_slot_pkg.sv
package cpu_slot_pkg;
    localparam logic [3:0] OFF_DATA2 = 4'h0;
    localparam logic [3:0] OFF_FLAGS = 4'h4;
    localparam logic [3:0] OFF_CMD   = 4'h5;
    localparam logic [3:0] OFF_DATA  = 4'h8;

    typedef enum logic [7:0] {
        CMD_NEXT_EVT = 8'd0,
        CMD_EVT_CODE = 8'd1,
        CMD_STS_CODE = 8'd2,
        CMD_ARCH_ID  = 8'd3
    } cmd_e;
endpackage

// File: rtl/cpu_slot_scan.sv
module cpu_slot_scan #(
    parameter int NSLOT = 8,
    localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [NSLOT-1:0] pend,
    input  logic [31:0]      start,
    output logic             found,
    output logic [IW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (pend[i] && (32'(i) >= start)) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cpu_slot_rdmux.sv
module cpu_slot_rdmux
    import cpu_slot_pkg::*;
(
    input  logic [3:0]  addr,
    input  logic [7:0]  cmd,
    input  logic [31:0] sel,
    input  logic        sel_ok,
    input  logic        en,
    input  logic        ins,
    input  logic        rem,
    input  logic [63:0] id,
    output logic [31:0] rdata
);
    always_comb begin
        rdata = '0;
        if (sel_ok) begin
            unique case (addr)
                OFF_DATA2: if (cmd == CMD_ARCH_ID) rdata = id[63:32];
                OFF_FLAGS: rdata = {29'd0, rem, ins, en};
                OFF_DATA: begin
                    if (cmd == CMD_NEXT_EVT)     rdata = sel;
                    else if (cmd == CMD_ARCH_ID) rdata = id[31:0];
                end
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cpu_slot_ctl.sv
module cpu_slot_ctl
    import cpu_slot_pkg::*;
#(
    parameter int NSLOT = 8,
    localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NSLOT-1:0]   slot_en,
    input  logic [NSLOT-1:0]   ins_set,
    input  logic [NSLOT-1:0]   rem_set,
    input  logic [NSLOT*64-1:0] slot_id,
    output logic               notify,
    output logic               rpt_valid,
    output logic [31:0]        rpt_event,
    output logic [31:0]        rpt_status
);
    typedef struct packed {
        logic [31:0]      sel;
        logic [7:0]       cmd;
        logic [31:0]      ev;
        logic [31:0]      st;
        logic             rpt;
        logic [NSLOT-1:0] ins;
        logic [NSLOT-1:0] rem;
    } state_t;

    state_t s_q, s_d;

    logic          sel_ok;
    logic [IW-1:0] sel_idx;
    logic          scan_found;
    logic [IW-1:0] scan_idx;
    logic [63:0]   cur_id;

    assign sel_ok  = s_q.sel < 32'(NSLOT);
    assign sel_idx = s_q.sel[IW-1:0];
    assign cur_id  = sel_ok ? slot_id[64*sel_idx +: 64] : 64'd0;

    cpu_slot_scan #(.NSLOT(NSLOT)) u_scan (
        .pend  (s_q.ins | s_q.rem),
        .start (s_q.sel),
        .found (scan_found),
        .idx   (scan_idx)
    );

    cpu_slot_rdmux u_rdmux (
        .addr   (addr),
        .cmd    (s_q.cmd),
        .sel    (s_q.sel),
        .sel_ok (sel_ok),
        .en     (sel_ok ? slot_en[sel_idx] : 1'b0),
        .ins    (sel_ok ? s_q.ins[sel_idx] : 1'b0),
        .rem    (sel_ok ? s_q.rem[sel_idx] : 1'b0),
        .id     (cur_id),
        .rdata  (rdata)
    );

    always_comb begin
        s_d     = s_q;
        s_d.rpt = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (wr_en && addr == OFF_FLAGS && sel_ok && sel_idx == IW'(i)) begin
                if (wdata[1]) s_d.ins[i] = 1'b0;
                if (wdata[2]) s_d.rem[i] = 1'b0;
            end
            if (ins_set[i]) s_d.ins[i] = 1'b1;
            if (rem_set[i]) s_d.rem[i] = 1'b1;
        end
        if (wr_en && addr == OFF_CMD) begin
            s_d.cmd = wdata[7:0];
            if (wdata[7:0] == CMD_NEXT_EVT && scan_found)
                s_d.sel = 32'(scan_idx);
        end
        if (wr_en && addr == OFF_DATA) begin
            if (s_q.cmd == CMD_EVT_CODE) begin
                s_d.ev = wdata;
            end else if (s_q.cmd == CMD_STS_CODE) begin
                s_d.st  = wdata;
                s_d.rpt = 1'b1;
            end else begin
                s_d.sel = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign notify     = |(s_q.ins | s_q.rem);
    assign rpt_valid  = s_q.rpt;
    assign rpt_event  = s_q.ev;
    assign rpt_status = s_q.st;

    // R11
    notify_after_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ins_set | rem_set)) |=> notify);

    // R9
    report_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_DATA && s_q.cmd == CMD_STS_CODE)
        |=> (rpt_valid && rpt_status == $past(wdata)));

    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr == OFF_DATA2 || addr == OFF_FLAGS || addr == OFF_DATA) |-> rdata == 32'd0);

    // R6
    bad_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && (addr == OFF_DATA2 || addr == OFF_DATA)) |-> rdata == 32'd0);

    // R4
    sel_hold_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CMD && wdata[7:0] != 8'd0) |=> $stable(s_q.sel));

    // R8
    evt_code_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_DATA && s_q.cmd == CMD_EVT_CODE)
        |=> ($stable(s_q.sel) && rpt_event == $past(wdata)));
endmodule

// File: tb/cpu_slot_ctl_bench.sv
module cpu_slot_ctl_bench;
    localparam int N = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [3:0]      addr = 4'h0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [N-1:0]    slot_en = 8'b1010_0101;
    logic [N-1:0]    ins_set = '0;
    logic [N-1:0]    rem_set = '0;
    logic [N*64-1:0] slot_id;
    logic            notify, rpt_valid;
    logic [31:0]     rpt_event, rpt_status;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++)
            slot_id[64*i +: 64] = {32'h5100_0000 + 32'(i), 32'hC0DE_0000 + 32'(i)};

    cpu_slot_ctl #(.NSLOT(N)) u_cpu_slot_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .slot_en(slot_en), .ins_set(ins_set), .rem_set(rem_set),
        .slot_id(slot_id), .notify(notify), .rpt_valid(rpt_valid),
        .rpt_event(rpt_event), .rpt_status(rpt_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 4'h0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(input logic ins, input int slot);
        @(negedge clk);
        if (ins) ins_set[slot] = 1'b1; else rem_set[slot] = 1'b1;
        @(negedge clk);
        ins_set = '0; rem_set = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'h8, d); chk("R1 data after reset", d, 32'd0);
        chk("R1 notify", {31'd0, notify}, 32'd0);
        chk("R1 event code", rpt_event, 32'd0);
        chk("R1 status code", rpt_status, 32'd0);
        rd(4'h4, d); chk("R1 slot0 flags", d, 32'h1);
    endtask

    task automatic t_status_and_notify();
        logic [31:0] d;
        pulse(1'b1, 2);
        chk("R11 notify after insert", {31'd0, notify}, 32'd1);
        pulse(1'b0, 5);
        wr(4'h8, 32'd2); rd(4'h4, d); chk("R2 slot2 insert", d, 32'h3);
        wr(4'h8, 32'd5); rd(4'h4, d); chk("R3 R2 slot5 remove", d, 32'h5);
        wr(4'h8, 32'd1); rd(4'h4, d); chk("R2 slot1 idle", d, 32'h0);
        rd(4'h8, d); chk("R3 selector readback", d, 32'd1);
    endtask

    task automatic t_search();
        logic [31:0] d;
        wr(4'h8, 32'd0); wr(4'h5, 32'd0);
        rd(4'h8, d); chk("R4 search from 0", d, 32'd2);
        wr(4'h8, 32'd3); wr(4'h5, 32'd0);
        rd(4'h8, d); chk("R4 search from 3", d, 32'd5);
        wr(4'h8, 32'd5); wr(4'h5, 32'd0);
        rd(4'h8, d); chk("R4 search at hit", d, 32'd5);
        wr(4'h8, 32'd6); wr(4'h5, 32'd0);
        rd(4'h8, d); chk("R4 no hit keeps selector", d, 32'd6);
    endtask

    task automatic t_arch_id();
        logic [31:0] d;
        wr(4'h8, 32'd7); wr(4'h5, 32'd3);
        rd(4'h8, d); chk("R5 id low", d, 32'hC0DE_0007);
        rd(4'h0, d); chk("R5 id high", d, 32'h5100_0007);
        wr(4'h8, 32'd4);
        rd(4'h0, d); chk("R3 R5 id high slot4", d, 32'h5100_0004);
        wr(4'h5, 32'd0);
        rd(4'h0, d); chk("R7 data2 under cmd0", d, 32'd0);
        wr(4'h5, 32'd9);
        rd(4'h8, d); chk("R7 data under reserved cmd", d, 32'd0);
        rd(4'h0, d); chk("R7 data2 under reserved cmd", d, 32'd0);
        wr(4'h8, 32'd3); wr(4'h5, 32'd0);
        rd(4'h8, d); chk("R3 selector load under reserved cmd", d, 32'd5);
    endtask

    task automatic t_out_of_range();
        logic [31:0] d;
        pulse(1'b1, 1);
        wr(4'h8, 32'd9); wr(4'h5, 32'd3);
        rd(4'h8, d); chk("R6 data zero", d, 32'd0);
        rd(4'h0, d); chk("R6 data2 zero", d, 32'd0);
        rd(4'h4, d); chk("R6 flags zero", d, 32'd0);
        wr(4'h5, 32'd0);
        rd(4'h8, d); chk("R6 data zero cmd0", d, 32'd0);
        wr(4'h4, 32'h6);
        wr(4'h8, 32'd1); rd(4'h4, d); chk("R6 clear had no effect", d, 32'h2);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(4'h8, 32'd1); wr(4'h4, 32'h1);
        rd(4'h4, d); chk("R10 bit0 ignored", d, 32'h2);
        wr(4'h4, 32'h2);
        rd(4'h4, d); chk("R10 clear slot1", d, 32'h0);
        wr(4'h8, 32'd2); wr(4'h4, 32'h4);
        rd(4'h4, d); chk("R10 remove bit no effect on insert", d, 32'h3);
        wr(4'h4, 32'h2);
        chk("R11 notify still high", {31'd0, notify}, 32'd1);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h4; wdata = 32'h2; ins_set[2] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ins_set = '0;
        rd(4'h4, d); chk("R10 set wins over clear", d, 32'h3);
        wr(4'h4, 32'h6);
        wr(4'h8, 32'd5); wr(4'h4, 32'h6);
        chk("R11 notify low after all cleared", {31'd0, notify}, 32'd0);
    endtask

    task automatic t_report();
        logic [31:0] d;
        wr(4'h8, 32'd3);
        wr(4'h5, 32'd1); wr(4'h8, 32'hAB);
        chk("R8 event code", rpt_event, 32'hAB);
        chk("R9 no pulse for event", {31'd0, rpt_valid}, 32'd0);
        rd(4'h8, d); chk("R7 data under cmd1", d, 32'd0);
        wr(4'h5, 32'd2); wr(4'h8, 32'h1234);
        chk("R9 pulse", {31'd0, rpt_valid}, 32'd1);
        chk("R9 status code", rpt_status, 32'h1234);
        chk("R9 event held", rpt_event, 32'hAB);
        @(negedge clk);
        chk("R9 pulse ends", {31'd0, rpt_valid}, 32'd0);
        rd(4'h8, d); chk("R7 data under cmd2", d, 32'd0);
        wr(4'h5, 32'd0);
        rd(4'h8, d); chk("R8 selector unchanged", d, 32'd3);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(4'h5, d); chk("R12 cmd byte reads zero", d, 32'd0);
        rd(4'h2, d); chk("R12 offset 2", d, 32'd0);
        rd(4'hC, d); chk("R12 offset C", d, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status_and_notify();
        t_search();
        t_arch_id();
        t_out_of_range();
        t_clear();
        t_report();
        t_unmapped();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule